// File: doc/BRIEF.md
# Precision-Scalable Signed Multiplier with Sub-Word Dot Product

This block is a registered signed multiplier over two 16-bit operands. A 3-bit mode input chooses between one full-width product and a packed dot product. In the packed modes each operand holds two or four signed sub-words, and the block returns the sum of the products of sub-words that share a lane. The block is meant to sit inside a precision-scalable multiply-accumulate datapath, where lower-precision data then costs fewer accumulation steps.

The core is a radix-4 Booth array of eight partial-product rows, a tree of 4:2 compressors and a parallel-prefix carry-propagate adder. No adder follows the products. The mode decides three things. It decides which bits of operand `a` form each Booth digit, with the digit chain broken at sub-word edges. It decides which sub-word of `b` feeds each row, pre-shifted so that every lane product lands at the same weight. It decides how far the summed result is shifted right so that the sum starts at bit 0. Rows that belong to one lane carry only that lane's `b` sub-word, with zeros below it, so the array never forms products between lanes. Operands are captured on one rising edge and the result appears on the next one.

Top module: `booth_st_mult`

## Requirements
- R1: With `mode` = 0, `prod` is the signed 32-bit product of `a` and `b`, each read as a signed 16-bit value.
- R2: With `mode` = 1, `prod` is `a` (signed 16-bit) times `b[7:0]` (signed 8-bit). `b[15:8]` has no effect on the result.
- R3: With `mode` = 2, `prod` = `a[15:8]*b[15:8] + a[7:0]*b[7:0]`, with every byte read as a signed value.
- R4: With `mode` = 3, `prod` = `a[15:8]*b[7:4] + a[7:0]*b[3:0]`, with every field read as a signed value. `b[15:8]` has no effect on the result.
- R5: With `mode` = 4, `prod` is the sum over i = 0..3 of `a[4i+3:4i]*b[4i+3:4i]`, with every nibble read as a signed value.
- R6: The `mode` values 5, 6 and 7 give the same result as `mode` = 0.
- R7: The inputs present at rising edge k set `prod` after rising edge k+1. The mode may change on every cycle, and each result follows the mode that was captured with its own operands.
- R8: While `rst_n` is low, `prod` is 0 and the captured operands are held at zero, whatever is driven on the inputs.
- R9: Most-negative sub-words give exact sums with no wrap. For example, 0x8000*0x8000 in mode 0 gives 2^30, 0x8080 with 0x8080 in mode 2 gives 32768, and 0x8888 with 0x8888 in mode 4 gives 256.
- R10: In every mode, an all-zero `a` or an all-zero `b` gives `prod` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| a | input | 16 | Operand A; one, two or four packed signed sub-words |
| b | input | 16 | Operand B; packed signed sub-words, lane meaning set by `mode` |
| mode | input | 3 | 0: 16x16, 1: 16x8, 2: 8x8 pair, 3: 8x4 pair, 4: 4x4 quad, other values: 16x16 |
| prod | output | 32 | Signed product or dot product, sign-extended, registered |

## Verification
The assertions check properties on every cycle that hold whatever the other operand is. A zero operand must give a zero result two edges later. A unit `a` in the wide modes must return `b` sign-extended, or only its low byte in 16x8. The result of each packed mode must stay inside the range that its lane products allow. Only the bench scenarios can show the exact lane sums. They can also show that the unused high bits of `b` are ignored in the asymmetric modes, that a result which changes mode on every cycle still follows its own mode, and that the most-negative sub-word cases produce exact values. The bench compares every output against a behavioural sum of sign-extended sub-word products.

// File: rtl/booth_st_mult.sv
`timescale 1ns/1ps
module booth_st_mult (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] a,
  input  logic [15:0] b,
  input  logic [2:0]  mode,
  output logic [31:0] prod
);
  localparam int OPW  = 16;
  localparam int RESW = 2 * OPW;
  localparam int ROWS = OPW / 2;
  localparam int LVLS = $clog2(RESW);

  logic [OPW-1:0] a_q, b_q;
  logic [2:0]     mode_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      a_q    <= '0;
      b_q    <= '0;
      mode_q <= '0;
    end else begin
      a_q    <= a;
      b_q    <= b;
      mode_q <= mode;
    end

  logic       byte_lanes, nib_lanes;
  logic [4:0] align;
  always_comb begin
    byte_lanes = (mode_q == 3'd2) || (mode_q == 3'd3);
    nib_lanes  = (mode_q == 3'd4);
    align      = nib_lanes ? 5'd12 : (byte_lanes ? 5'd8 : 5'd0);
  end

  logic [ROWS-1:1] cut;
  always_comb begin
    cut = '0;
    if (byte_lanes) cut[4] = 1'b1;
    if (nib_lanes) begin
      cut[2] = 1'b1;
      cut[4] = 1'b1;
      cut[6] = 1'b1;
    end
  end

  function automatic logic [OPW-1:0] lane_b(input int row, input logic [2:0] md,
                                             input logic [OPW-1:0] bv);
    case (md)
      3'd1: return {{8{bv[7]}}, bv[7:0]};
      3'd2: return (row < 4) ? {bv[7:0], 8'h00} : {{8{bv[15]}}, bv[15:8]};
      3'd3: return (row < 4) ? {{4{bv[3]}}, bv[3:0], 8'h00} : {{12{bv[7]}}, bv[7:4]};
      3'd4:
        case (row / 2)
          0:       return {bv[3:0], 12'h000};
          1:       return {{4{bv[7]}}, bv[7:4], 8'h00};
          2:       return {{8{bv[11]}}, bv[11:8], 4'h0};
          default: return {{12{bv[15]}}, bv[15:12]};
        endcase
      default: return bv;
    endcase
  endfunction

  logic [ROWS-1:0][RESW-1:0] rows;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [2:0]     trip;
    logic [OPW-1:0] y;
    logic           neg, one, two;
    logic [OPW:0]   mag;
    logic [OPW+1:0] ext, pp;

    if (r == 0) begin : g_first
      assign trip = {a_q[1], a_q[0], 1'b0};
    end else begin : g_rest
      assign trip = {a_q[2*r+1], a_q[2*r], cut[r] ? 1'b0 : a_q[2*r-1]};
    end

    assign y   = lane_b(r, mode_q, b_q);
    assign neg = trip[2];
    assign one = trip[1] ^ trip[0];
    assign two = (trip[2] & ~trip[1] & ~trip[0]) | (~trip[2] & trip[1] & trip[0]);
    assign mag = one ? {y[OPW-1], y} : (two ? {y, 1'b0} : '0);
    assign ext = {mag[OPW], mag};
    assign pp  = neg ? (~ext + 1'b1) : ext;
    assign rows[r] = {{(RESW-OPW-2){pp[OPW+1]}}, pp} << (2 * r);
  end

  function automatic logic [2*RESW-1:0] comp42(input logic [RESW-1:0] w, x, y, z);
    logic [RESW-1:0] s1, c1, s2, c2;
    s1 = w ^ x ^ y;
    c1 = ((w & x) | (w & y) | (x & y)) << 1;
    s2 = s1 ^ z ^ c1;
    c2 = ((s1 & z) | (s1 & c1) | (z & c1)) << 1;
    return {c2, s2};
  endfunction

  logic [RESW-1:0] l1_s0, l1_c0, l1_s1, l1_c1, fin_s, fin_c;
  assign {l1_c0, l1_s0} = comp42(rows[0], rows[1], rows[2], rows[3]);
  assign {l1_c1, l1_s1} = comp42(rows[4], rows[5], rows[6], rows[7]);
  assign {fin_c, fin_s} = comp42(l1_s0, l1_c0, l1_s1, l1_c1);

  logic [LVLS:0][RESW-1:0]   gen;
  logic [LVLS-1:0][RESW-1:0] prp;
  logic [RESW-1:0]           half, total;

  assign half   = fin_s ^ fin_c;
  assign gen[0] = fin_s & fin_c;
  assign prp[0] = half;

  for (genvar k = 0; k < LVLS; k++) begin : g_pfx
    localparam int D = 1 << k;
    assign gen[k+1] = gen[k] | (prp[k] & (gen[k] << D));
    if (k < LVLS - 1) begin : g_p
      assign prp[k+1] = prp[k] & ((prp[k] << D) | RESW'((64'd1 << D) - 1));
    end
  end

  assign total = half ^ (gen[LVLS] << 1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prod <= '0;
    else        prod <= RESW'($signed(total) >>> align);
endmodule

module booth_st_mult_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] a,
  input logic [15:0] b,
  input logic [2:0]  mode,
  input logic [31:0] prod
);
  // R10
  a_r10_zero_a: assert property (@(posedge clk) disable iff (!rst_n)
    (a == 16'h0) |=> ##1 (prod == 32'h0));
  // R10
  a_r10_zero_b: assert property (@(posedge clk) disable iff (!rst_n)
    (b == 16'h0) |=> ##1 (prod == 32'h0));
  // R1
  a_r1_unit_a: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd0 && a == 16'h0001) |=> ##1 ($signed(prod) == $signed($past(b, 2))));
  // R6
  a_r6_unit_a_alias: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd6 && a == 16'h0001) |=> ##1 ($signed(prod) == $signed($past(b, 2))));
  // R2
  a_r2_unit_a_low: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd1 && a == 16'h0001) |=> ##1
      ($signed(prod) == $signed($past(b[7:0], 2))));
  // R3
  a_r3_pair_range: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd2) |=> ##1 ($signed(prod) <= 32768 && $signed(prod) >= -32512));
  // R5
  a_r5_quad_range: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd4) |=> ##1 ($signed(prod) <= 256 && $signed(prod) >= -224));
endmodule

bind booth_st_mult booth_st_mult_chk u_chk (.*);

// File: tb/booth_st_mult_bench.sv
`timescale 1ns/1ps
module booth_st_mult_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] a = '0, b = '0;
  logic [2:0]  mode = '0;
  logic [31:0] prod;

  int total = 0;
  int bad = 0;

  longint exp_q[$];
  string  tag_q[$];

  booth_st_mult u_booth_st_mult (
    .clk(clk), .rst_n(rst_n), .a(a), .b(b), .mode(mode), .prod(prod)
  );

  always #2.5 clk = ~clk;

  function automatic longint fld(input logic [15:0] v, input int lo, input int w);
    longint t;
    t = longint'((v >> lo) & ((16'h1 << w) - 16'h1));
    if (t >= (longint'(1) << (w - 1))) t = t - (longint'(1) << w);
    return t;
  endfunction

  function automatic longint model(input logic [15:0] av, input logic [15:0] bv,
                                   input logic [2:0] md);
    longint s;
    s = 0;
    case (md)
      3'd1: s = fld(av, 0, 16) * fld(bv, 0, 8);
      3'd2: s = fld(av, 8, 8) * fld(bv, 8, 8) + fld(av, 0, 8) * fld(bv, 0, 8);
      3'd3: s = fld(av, 8, 8) * fld(bv, 4, 4) + fld(av, 0, 8) * fld(bv, 0, 4);
      3'd4: for (int i = 0; i < 4; i++) s += fld(av, 4*i, 4) * fld(bv, 4*i, 4);
      default: s = fld(av, 0, 16) * fld(bv, 0, 16);
    endcase
    return s;
  endfunction

  task automatic check(input longint act, input longint exp, input string tag);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic [15:0] av, input logic [15:0] bv,
                      input logic [2:0] md, input string tag);
    @(negedge clk);
    if (exp_q.size() == 2) begin
      check(longint'($signed(prod)), exp_q.pop_front(), tag_q.pop_front());
    end
    a = av;
    b = bv;
    mode = md;
    exp_q.push_back(model(av, bv, md));
    tag_q.push_back(tag);
  endtask

  initial begin
    #(5.0 * 100000);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    a = 16'hFFFF; b = 16'hFFFF; mode = 3'd0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(longint'(prod), 0, "R8 reset");
    end
    a = '0; b = '0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(longint'(prod), 0, "R8 cleared");

    step(16'h8000, 16'h8000, 3'd0, "R9 16x16 minneg");
    step(16'h8000, 16'h7FFF, 3'd0, "R9 16x16");
    step(16'hFFFF, 16'hFFFF, 3'd0, "R1 -1*-1");
    step(16'h8000, 16'hFF80, 3'd1, "R9 16x8");
    step(16'h0003, 16'h7F80, 3'd1, "R2 upper b ignored");
    step(16'h8080, 16'h8080, 3'd2, "R9 8x8 minneg");
    step(16'hFFFF, 16'h8080, 3'd2, "R3 -1 lanes");
    step(16'h8080, 16'hFF88, 3'd3, "R9 8x4");
    step(16'hFF80, 16'h5A8F, 3'd3, "R4 upper b ignored");
    step(16'h8888, 16'h8888, 3'd4, "R9 4x4 minneg");
    step(16'hFFFF, 16'h8888, 3'd4, "R5 -1 nibbles");
    step(16'h7777, 16'h8888, 3'd4, "R5 max*min");
    for (int md = 5; md < 8; md++) step(16'h8001, 16'h7FFF, 3'(md), "R6 alias");
    for (int md = 0; md < 8; md++) begin
      step(16'h0000, 16'(($urandom)), 3'(md), "R10 zero a");
      step(16'(($urandom)), 16'h0000, 3'(md), "R10 zero b");
    end

    for (int n = 0; n < 600; n++) begin
      logic [2:0] md;
      md = 3'(n % 5);
      case (md)
        3'd0: step(16'($urandom), 16'($urandom), md, "R1 random");
        3'd1: step(16'($urandom), 16'($urandom), md, "R2 random");
        3'd2: step(16'($urandom), 16'($urandom), md, "R3 random");
        3'd3: step(16'($urandom), 16'($urandom), md, "R4 random");
        default: step(16'($urandom), 16'($urandom), md, "R5 random");
      endcase
    end
    for (int n = 0; n < 200; n++)
      step(16'($urandom), 16'($urandom), 3'($urandom), "R7 mode change each cycle");
    for (int n = 0; n < 100; n++)
      step(16'($urandom), 16'($urandom), 3'(5 + n % 3), "R6 random");

    step(16'h0000, 16'h0000, 3'd0, "R10 flush");
    step(16'h0000, 16'h0000, 3'd0, "R10 flush");
    step(16'h0000, 16'h0000, 3'd0, "R10 flush");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule